// File: doc/BRIEF.md
# Programmable Reversible Gate Cascade Evaluator

This block holds a list of up to `MAXG` reversible gate descriptors. It applies them one by one to an `NWIRE`-bit data word, where each bit is one wire. Each descriptor has three fields:

- a gate kind: inversion, singly-controlled inversion, multiply-controlled inversion, or exchange;
- a wire mask;
- a target wire index.

A configuration port appends descriptors to the list or empties it. Descriptors that break the encoding rules, or that arrive when the list is full, are refused and flagged.

A word offered on the data port with a valid/ready handshake is carried through the whole list. The list is walked from first-loaded to last-loaded, or in the opposite order when the reverse input is set. The result then appears on the output for one cycle, with a valid pulse.

Every gate is its own inverse. Running the list in reverse order therefore computes the inverse of the forward mapping, and a forward pass followed by a reverse pass gives back the original word. The mapping over all input words is always a bijection.

Top module: `rgc_cascade`

## Requirements
- R1: After reset, `in_ready` and `cfg_ready` are 1, `out_valid` and `cfg_err` are 0, `out_data` is 0 and the list is empty, so a word evaluated right after reset comes back unchanged.
- R2: Kind 2'b00 (inversion) flips the target wire on every word and leaves all other wires as they were; its mask is ignored and never causes a refusal.
- R3: Kind 2'b01 (single control) needs exactly one mask bit; the target wire becomes target XOR control, and all other wires pass through.
- R4: Kind 2'b10 (multi control) flips the target only when every masked wire is 1; an all-zero mask flips the target on every word.
- R5: Kind 2'b11 (exchange) swaps the target wire with the lowest-numbered set bit of the mask; higher mask bits have no effect.
- R6: With `in_rev` = 0, descriptors are applied in the order they were loaded.
- R7: With `in_rev` = 1, descriptors are applied from the last loaded to the first, so reverse evaluation of a forward result returns the original word.
- R8: With G descriptors loaded, `out_valid` is high for exactly one cycle, G+1 cycles after the edge that accepts the word; `out_data` holds its value until the next result.
- R9: From acceptance until the result cycle, `in_ready` and `cfg_ready` are 0, and words or descriptors offered in that period are ignored.
- R10: A descriptor is refused when any of these holds: its target is not below `NWIRE`; a non-inversion kind has the target bit set in its mask; a single-control kind has a mask without exactly one set bit; an exchange has an empty mask; the list already holds `MAXG` entries. A refused descriptor raises `cfg_err` for the single cycle after the write and is not stored.
- R11: `cfg_clear` (taking priority over a simultaneous write) empties the list, which then behaves as the identity with a latency of one cycle.
- R12: For any loaded list, the results for all 2^NWIRE input words are pairwise distinct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_clear | input | 1 | Empty the gate list (when `cfg_ready`) |
| cfg_valid | input | 1 | Append a descriptor (when `cfg_ready`) |
| cfg_kind | input | 2 | Gate kind: 00 inversion, 01 single control, 10 multi control, 11 exchange |
| cfg_mask | input | NWIRE | Control mask, or exchange partner selection |
| cfg_tgt | input | 3 | Target wire index |
| cfg_ready | output | 1 | Configuration accepted this cycle |
| cfg_err | output | 1 | One-cycle flag after a refused descriptor |
| in_valid | input | 1 | Data word offered |
| in_rev | input | 1 | Evaluate the list in reverse order |
| in_data | input | NWIRE | Data word |
| in_ready | output | 1 | Block idle, word accepted when valid |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | NWIRE | Transformed word |

## Verification
Each gate kind is first tried alone, on words chosen so that control conditions are both met and missed. This separates a correct condition from one that always fires or never fires. It also shows whether the exchange picks the lowest mask bit rather than any other.

A two-gate list whose gates do not commute is run forwards and backwards. This tells the two orderings apart, and a forward result fed back in reverse must reproduce its input.

A random list is driven with all 256 words and the results are checked to be distinct. The list is also filled to capacity with an even number of identical inversions, so that a wrongly stored extra entry or a wrong latency shows in the result.

// File: rtl/rgc_pkg.sv
package rgc_pkg;
   // Wire index field width; the block supports at most 2**TGT_W wires.
   localparam int TGT_W      = 3;
   localparam int WIRE_LIMIT = 8;

   typedef enum logic [1:0] {
      GK_INV  = 2'b00,
      GK_CX   = 2'b01,
      GK_MCX  = 2'b10,
      GK_XCHG = 2'b11
   } gate_kind_e;

   typedef enum logic {
      SQ_IDLE = 1'b0,
      SQ_RUN  = 1'b1
   } seq_state_e;
endpackage

// File: rtl/rgc_desc_check.sv
// Combinational legality check of one incoming gate descriptor.
module rgc_desc_check
   import rgc_pkg::*;
#(
   parameter int NWIRE = 8
) (
   input  gate_kind_e         kind,
   input  logic [NWIRE-1:0]   mask,
   input  logic [TGT_W-1:0]   tgt,
   output logic               legal
);
   logic [NWIRE-1:0] tsel;
   logic             in_range;
   logic             overlap;
   logic             nonempty;
   logic             single;

   for (genvar w = 0; w < NWIRE; w++) begin : g_tsel
      assign tsel[w] = (tgt == TGT_W'(w));
   end

   // With a full-width wire count every encodable index is in range.
   if (NWIRE == WIRE_LIMIT) begin : g_full_range
      assign in_range = 1'b1;
   end else begin : g_part_range
      assign in_range = (tgt < TGT_W'(NWIRE));
   end

   assign overlap  = |(mask & tsel);
   assign nonempty = |mask;
   assign single   = nonempty && ((mask & (mask - NWIRE'(1))) == '0);

   assign legal = in_range
                  && ((kind == GK_INV) || !overlap)
                  && ((kind != GK_CX)  || single)
                  && ((kind != GK_XCHG) || nonempty);
endmodule

// File: rtl/rgc_gate_store.sv
// Descriptor list: append-only storage with a fill count and a read port.
module rgc_gate_store
   import rgc_pkg::*;
#(
   parameter int NWIRE = 8,
   parameter int MAXG  = 32
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  clr,
   input  logic                                  wr_en,
   input  logic                                  wr_legal,
   input  gate_kind_e                            wr_kind,
   input  logic [NWIRE-1:0]                      wr_mask,
   input  logic [TGT_W-1:0]                      wr_tgt,
   output logic                                  wr_reject,
   output logic [$clog2(MAXG+1)-1:0]             count,
   input  logic [((MAXG > 1) ? $clog2(MAXG) : 1)-1:0] rd_idx,
   output gate_kind_e                            rd_kind,
   output logic [NWIRE-1:0]                      rd_mask,
   output logic [TGT_W-1:0]                      rd_tgt
);
   localparam int CW = $clog2(MAXG + 1);
   localparam int IW = (MAXG > 1) ? $clog2(MAXG) : 1;
   localparam int DW = 2 + NWIRE + TGT_W;

   logic [DW-1:0] slot_q [MAXG];
   logic          room;
   logic          take;
   logic [DW-1:0] rd_word;

   assign room      = (count < CW'(MAXG));
   assign take      = wr_en && wr_legal && room;
   assign wr_reject = wr_en && !take;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clr) begin
         count <= '0;
      end else if (take) begin
         count <= count + CW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (take && !clr) begin
         slot_q[count[IW-1:0]] <= {wr_kind, wr_mask, wr_tgt};
      end
   end

   assign rd_word = slot_q[rd_idx];
   assign rd_kind = gate_kind_e'(rd_word[DW-1 -: 2]);
   assign rd_mask = rd_word[TGT_W +: NWIRE];
   assign rd_tgt  = rd_word[TGT_W-1:0];
endmodule

// File: rtl/rgc_gate_apply.sv
// Applies one reversible gate to a word, one slice of logic per wire.
module rgc_gate_apply
   import rgc_pkg::*;
#(
   parameter int NWIRE = 8
) (
   input  gate_kind_e         kind,
   input  logic [NWIRE-1:0]   mask,
   input  logic [TGT_W-1:0]   tgt,
   input  logic [NWIRE-1:0]   din,
   output logic [NWIRE-1:0]   dout
);
   logic [NWIRE-1:0] tsel;
   logic [NWIRE-1:0] partner;
   logic             all_set;
   logic             tgt_val;
   logic             partner_val;
   logic             flip_ok;
   logic             is_xchg;

   // Lowest set mask bit in one-hot form picks the exchange partner.
   assign partner     = mask & (~mask + NWIRE'(1));
   assign all_set     = &(din | ~mask);
   assign tgt_val     = |(din & tsel);
   assign partner_val = |(din & partner);
   assign is_xchg     = (kind == GK_XCHG);
   assign flip_ok     = (kind == GK_INV) || all_set;

   for (genvar w = 0; w < NWIRE; w++) begin : g_wire
      assign tsel[w] = (tgt == TGT_W'(w));
      assign dout[w] = is_xchg
                       ? (tsel[w] ? partner_val : (partner[w] ? tgt_val : din[w]))
                       : (din[w] ^ (tsel[w] & flip_ok));
   end
endmodule

// File: rtl/rgc_sequencer.sv
// Walks the gate list one entry per cycle, forwards or backwards.
module rgc_sequencer
   import rgc_pkg::*;
#(
   parameter int NWIRE = 8,
   parameter int MAXG  = 32
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  in_valid,
   input  logic                                  in_rev,
   input  logic [NWIRE-1:0]                      in_data,
   output logic                                  in_ready,
   input  logic [$clog2(MAXG+1)-1:0]             n_gates,
   output logic [((MAXG > 1) ? $clog2(MAXG) : 1)-1:0] rd_idx,
   output logic [NWIRE-1:0]                      work,
   input  logic [NWIRE-1:0]                      stepped,
   output logic                                  out_valid,
   output logic [NWIRE-1:0]                      out_data
);
   localparam int CW = $clog2(MAXG + 1);
   localparam int IW = (MAXG > 1) ? $clog2(MAXG) : 1;

   seq_state_e      state;
   logic [CW-1:0]   left;
   logic [IW-1:0]   idx;
   logic            rev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SQ_IDLE;
         left      <= '0;
         idx       <= '0;
         rev       <= 1'b0;
         work      <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= 1'b0;
         unique case (state)
            SQ_IDLE: begin
               if (in_valid) begin
                  work  <= in_data;
                  left  <= n_gates;
                  rev   <= in_rev;
                  idx   <= in_rev ? IW'(n_gates - CW'(1)) : '0;
                  state <= SQ_RUN;
               end
            end
            SQ_RUN: begin
               if (left == '0) begin
                  out_valid <= 1'b1;
                  out_data  <= work;
                  state     <= SQ_IDLE;
               end else begin
                  work <= stepped;
                  left <= left - CW'(1);
                  idx  <= rev ? (idx - IW'(1)) : (idx + IW'(1));
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   assign in_ready = (state == SQ_IDLE);
   assign rd_idx   = idx;
endmodule

// File: rtl/rgc_cascade.sv
// Top level: programmable list of reversible gates evaluated serially.
module rgc_cascade
   import rgc_pkg::*;
#(
   parameter int NWIRE = 8,
   parameter int MAXG  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_clear,
   input  logic               cfg_valid,
   input  logic [1:0]         cfg_kind,
   input  logic [NWIRE-1:0]   cfg_mask,
   input  logic [2:0]         cfg_tgt,
   output logic               cfg_ready,
   output logic               cfg_err,
   input  logic               in_valid,
   input  logic               in_rev,
   input  logic [NWIRE-1:0]   in_data,
   output logic               in_ready,
   output logic               out_valid,
   output logic [NWIRE-1:0]   out_data
);
   localparam int CW = $clog2(MAXG + 1);
   localparam int IW = (MAXG > 1) ? $clog2(MAXG) : 1;

   if (NWIRE < 2 || NWIRE > WIRE_LIMIT) begin : g_bad_nwire
      $error("rgc_cascade: NWIRE must lie in 2..%0d", WIRE_LIMIT);
   end
   if (MAXG < 1) begin : g_bad_maxg
      $error("rgc_cascade: MAXG must be at least 1");
   end

   gate_kind_e        wr_kind;
   logic              wr_legal;
   logic              wr_reject;
   logic              store_clr;
   logic              store_wr;
   logic [CW-1:0]     gate_cnt;
   logic [IW-1:0]     rd_idx;
   gate_kind_e        rd_kind;
   logic [NWIRE-1:0]  rd_mask;
   logic [2:0]        rd_tgt;
   logic [NWIRE-1:0]  work;
   logic [NWIRE-1:0]  stepped;

   assign wr_kind   = gate_kind_e'(cfg_kind);
   assign cfg_ready = in_ready;
   assign store_clr = cfg_clear && cfg_ready;
   assign store_wr  = cfg_valid && cfg_ready && !cfg_clear;

   rgc_desc_check #(.NWIRE(NWIRE)) u_check (
      .kind  (wr_kind),
      .mask  (cfg_mask),
      .tgt   (cfg_tgt),
      .legal (wr_legal)
   );

   rgc_gate_store #(.NWIRE(NWIRE), .MAXG(MAXG)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (store_clr),
      .wr_en     (store_wr),
      .wr_legal  (wr_legal),
      .wr_kind   (wr_kind),
      .wr_mask   (cfg_mask),
      .wr_tgt    (cfg_tgt),
      .wr_reject (wr_reject),
      .count     (gate_cnt),
      .rd_idx    (rd_idx),
      .rd_kind   (rd_kind),
      .rd_mask   (rd_mask),
      .rd_tgt    (rd_tgt)
   );

   rgc_gate_apply #(.NWIRE(NWIRE)) u_apply (
      .kind (rd_kind),
      .mask (rd_mask),
      .tgt  (rd_tgt),
      .din  (work),
      .dout (stepped)
   );

   rgc_sequencer #(.NWIRE(NWIRE), .MAXG(MAXG)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_rev    (in_rev),
      .in_data   (in_data),
      .in_ready  (in_ready),
      .n_gates   (gate_cnt),
      .rd_idx    (rd_idx),
      .work      (work),
      .stepped   (stepped),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_err <= 1'b0;
      end else begin
         cfg_err <= wr_reject;
      end
   end
endmodule

// File: rtl/rgc_cascade_chk.sv
// Protocol and timing checker, bound into every rgc_cascade instance.
module rgc_cascade_chk #(
   parameter int NWIRE = 8,
   parameter int MAXG  = 32
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        cfg_clear,
   input logic                        cfg_valid,
   input logic                        cfg_ready,
   input logic                        cfg_err,
   input logic                        in_valid,
   input logic                        in_ready,
   input logic                        out_valid,
   input logic [NWIRE-1:0]            out_data,
   input logic [$clog2(MAXG+1)-1:0]   n_gates
);
   localparam int CW = $clog2(MAXG + 1);
   localparam int LW = CW + 1;

   logic          pending;
   logic [LW-1:0] lat;
   logic [LW-1:0] exp_lat;

   // Cycle counter from acceptance, compared against the list length.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= 1'b0;
         lat     <= '0;
         exp_lat <= '0;
      end else if (in_valid && in_ready) begin
         pending <= 1'b1;
         lat     <= '0;
         exp_lat <= LW'(n_gates) + LW'(1);
      end else if (pending) begin
         lat <= lat + LW'(1);
         if (out_valid) pending <= 1'b0;
      end
   end

   p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pending |-> (out_valid == (lat == exp_lat)));

   p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_data));

   p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (!in_ready && !cfg_ready));

   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> in_ready);

   p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> $past(cfg_valid && cfg_ready && !cfg_clear));

   p_err_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_err && !$past(cfg_valid && cfg_ready)) |-> 1'b0);

   p_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
      n_gates <= CW'(MAXG));

   p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_clear && cfg_ready) |=> (n_gates == '0));
endmodule

bind rgc_cascade rgc_cascade_chk #(.NWIRE(NWIRE), .MAXG(MAXG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_clear (cfg_clear),
   .cfg_valid (cfg_valid),
   .cfg_ready (cfg_ready),
   .cfg_err   (cfg_err),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_data  (out_data),
   .n_gates   (gate_cnt)
);

// File: tb/test_rgc_cascade.sv
module test_rgc_cascade;
   localparam int CLK_PERIOD = 10;
   localparam int NW = 8;
   localparam int MG = 32;

   typedef struct {
      logic [1:0]    kind;
      logic [NW-1:0] mask;
      logic [2:0]    tgt;
   } gdesc_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_clear = 1'b0;
   logic          cfg_valid = 1'b0;
   logic [1:0]    cfg_kind = '0;
   logic [NW-1:0] cfg_mask = '0;
   logic [2:0]    cfg_tgt = '0;
   logic          cfg_ready;
   logic          cfg_err;
   logic          in_valid = 1'b0;
   logic          in_rev = 1'b0;
   logic [NW-1:0] in_data = '0;
   logic          in_ready;
   logic          out_valid;
   logic [NW-1:0] out_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // Reference model state
   gdesc_t        q[$];
   bit            m_busy = 0;
   int            m_left = 0;
   logic [NW-1:0] m_res = '0;
   bit            m_ov = 0;
   logic [NW-1:0] m_od = '0;
   bit            m_err = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rgc_cascade #(.NWIRE(NW), .MAXG(MG)) i_rgc_cascade (
      .clk(clk), .rst_n(rst_n),
      .cfg_clear(cfg_clear), .cfg_valid(cfg_valid), .cfg_kind(cfg_kind),
      .cfg_mask(cfg_mask), .cfg_tgt(cfg_tgt), .cfg_ready(cfg_ready), .cfg_err(cfg_err),
      .in_valid(in_valid), .in_rev(in_rev), .in_data(in_data), .in_ready(in_ready),
      .out_valid(out_valid), .out_data(out_data)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [NW-1:0] ref_gate(input logic [NW-1:0] w, input gdesc_t g);
      logic [NW-1:0] v = w;
      case (g.kind)
         2'd0: v[g.tgt] = ~v[g.tgt];
         2'd1, 2'd2: begin
            bit all = 1;
            for (int i = 0; i < NW; i++) if (g.mask[i] && !v[i]) all = 0;
            if (all) v[g.tgt] = ~v[g.tgt];
         end
         default: begin
            int p = -1;
            logic t;
            for (int i = NW-1; i >= 0; i--) if (g.mask[i]) p = i;
            if (p >= 0) begin
               t = v[g.tgt];
               v[g.tgt] = v[p];
               v[p] = t;
            end
         end
      endcase
      return v;
   endfunction

   function automatic logic [NW-1:0] ref_eval(input logic [NW-1:0] w, input bit rev);
      logic [NW-1:0] v = w;
      int n = q.size();
      for (int s = 0; s < n; s++) begin
         gdesc_t g;
         g = rev ? q[n-1-s] : q[s];
         v = ref_gate(v, g);
      end
      return v;
   endfunction

   function automatic bit ref_legal(input logic [1:0] k, input logic [NW-1:0] m, input logic [2:0] t);
      if (int'(t) >= NW) return 0;
      if (k != 2'd0 && m[t]) return 0;
      if (k == 2'd1 && $countones(m) != 1) return 0;
      if (k == 2'd3 && m == '0) return 0;
      return 1;
   endfunction

   // Cycle-by-cycle reference model, updated on the active edge.
   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete();
         m_busy = 0; m_left = 0; m_ov = 0; m_od = '0; m_err = 0;
      end else begin
         m_ov = 0;
         m_err = 0;
         if (m_busy) begin
            if (m_left == 0) begin
               m_ov = 1; m_od = m_res; m_busy = 0;
            end else begin
               m_left--;
            end
         end else begin
            if (in_valid) begin
               m_res = ref_eval(in_data, in_rev);
               m_left = q.size();
               m_busy = 1;
            end
            if (cfg_clear) begin
               q.delete();
            end else if (cfg_valid) begin
               if (ref_legal(cfg_kind, cfg_mask, cfg_tgt) && q.size() < MG) begin
                  gdesc_t g;
                  g.kind = cfg_kind; g.mask = cfg_mask; g.tgt = cfg_tgt;
                  q.push_back(g);
               end else begin
                  m_err = 1;
               end
            end
         end
      end
   end

   // Compare on every clock, away from the active edge.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(in_ready == !m_busy, "R9 in_ready", 32'(in_ready), 32'(!m_busy));
         chk(cfg_ready == !m_busy, "R9 cfg_ready", 32'(cfg_ready), 32'(!m_busy));
         chk(out_valid == m_ov, "R8 out_valid", 32'(out_valid), 32'(m_ov));
         chk(out_data == m_od, "R8 out_data", 32'(out_data), 32'(m_od));
         chk(cfg_err == m_err, "R10 cfg_err", 32'(cfg_err), 32'(m_err));
      end
   end

   task automatic cfg_put(input logic [1:0] k, input logic [NW-1:0] m, input logic [2:0] t,
                          input bit exp_err, input string tag);
      @(negedge clk);
      while (!cfg_ready) @(negedge clk);
      cfg_valid = 1; cfg_kind = k; cfg_mask = m; cfg_tgt = t;
      @(negedge clk);
      cfg_valid = 0;
      chk(cfg_err == exp_err, tag, 32'(cfg_err), 32'(exp_err));
   endtask

   task automatic cfg_wipe();
      @(negedge clk);
      while (!cfg_ready) @(negedge clk);
      cfg_clear = 1;
      @(negedge clk);
      cfg_clear = 0;
   endtask

   task automatic run(input logic [NW-1:0] w, input bit rev, output logic [NW-1:0] res, output int lat);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1; in_data = w; in_rev = rev;
      @(negedge clk);
      in_valid = 0;
      lat = 0;
      while (!out_valid && lat < 200) begin
         @(negedge clk);
         lat++;
      end
      res = out_data;
   endtask

   task automatic load_random(input int n);
      for (int s = 0; s < n; s++) begin
         logic [1:0]    k = 2'($urandom_range(0, 3));
         logic [2:0]    t = 3'($urandom_range(0, NW-1));
         logic [NW-1:0] m = NW'($urandom) & NW'($urandom);
         m[t] = 1'b0;
         if (k == 2'd1) m = NW'(1) << ((int'(t) + 1 + $urandom_range(0, NW-2)) % NW);
         if (k == 2'd3 && m == '0) m = NW'(1) << ((int'(t) + 1) % NW);
         cfg_put(k, m, t, 1'b0, "R10 legal random write");
      end
   endtask

   initial begin
      logic [NW-1:0] r;
      logic [NW-1:0] r2;
      int lat;
      bit seen [256];
      int dup;

      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(in_ready == 1, "R1 in_ready", 32'(in_ready), 1);
      chk(cfg_ready == 1, "R1 cfg_ready", 32'(cfg_ready), 1);
      chk(out_valid == 0, "R1 out_valid", 32'(out_valid), 0);
      chk(cfg_err == 0, "R1 cfg_err", 32'(cfg_err), 0);
      chk(out_data == 0, "R1 out_data", 32'(out_data), 0);
      run(8'hC3, 0, r, lat);
      chk(r == 8'hC3, "R1 empty list identity", 32'(r), 32'hC3);
      chk(lat == 1, "R1 empty list latency", 32'(lat), 1);

      // R2 inversion, mask ignored
      cfg_put(2'd0, 8'hFF, 3'd3, 1'b0, "R2 inversion with full mask accepted");
      run(8'h00, 0, r, lat);
      chk(r == 8'h08, "R2 inversion on zero", 32'(r), 32'h08);
      run(8'hFF, 0, r, lat);
      chk(r == 8'hF7, "R2 inversion on ones", 32'(r), 32'hF7);

      // R3 single control: wire1 controls wire0
      cfg_wipe();
      cfg_put(2'd1, 8'h02, 3'd0, 1'b0, "R3 single control accepted");
      for (int w = 0; w < 8; w++) begin
         logic [NW-1:0] wi = NW'(w) | 8'hA0;
         logic [NW-1:0] ex = {wi[7:1], wi[1] ^ wi[0]};
         run(wi, 0, r, lat);
         chk(r == ex, "R3 xor truth table", 32'(r), 32'(ex));
      end

      // R4 multi control
      cfg_wipe();
      cfg_put(2'd2, 8'h05, 3'd7, 1'b0, "R4 multi control accepted");
      run(8'h05, 0, r, lat);
      chk(r == 8'h85, "R4 all controls set", 32'(r), 32'h85);
      run(8'h04, 0, r, lat);
      chk(r == 8'h04, "R4 one control clear", 32'(r), 32'h04);
      cfg_wipe();
      cfg_put(2'd2, 8'h00, 3'd2, 1'b0, "R4 empty mask accepted");
      run(8'h00, 0, r, lat);
      chk(r == 8'h04, "R4 empty mask flips", 32'(r), 32'h04);

      // R5 exchange with lowest mask bit
      cfg_wipe();
      cfg_put(2'd3, 8'h0A, 3'd6, 1'b0, "R5 exchange accepted");
      run(8'h02, 0, r, lat);
      chk(r == 8'h40, "R5 partner to target", 32'(r), 32'h40);
      run(8'h48, 0, r, lat);
      chk(r == 8'h0A, "R5 target to partner, upper mask bit untouched", 32'(r), 32'h0A);

      // R6 / R7 ordering with non-commuting gates
      cfg_wipe();
      cfg_put(2'd0, 8'h00, 3'd0, 1'b0, "R6 load first");
      cfg_put(2'd1, 8'h01, 3'd1, 1'b0, "R6 load second");
      run(8'h00, 0, r, lat);
      chk(r == 8'h03, "R6 forward order", 32'(r), 32'h03);
      chk(lat == 3, "R8 latency two gates", 32'(lat), 3);
      run(8'h00, 1, r, lat);
      chk(r == 8'h01, "R7 reverse order", 32'(r), 32'h01);
      run(8'h03, 1, r, lat);
      chk(r == 8'h00, "R7 reverse undoes forward", 32'(r), 32'h00);

      // R9 offers while busy are ignored
      @(negedge clk);
      in_valid = 1; in_data = 8'h00; in_rev = 0;
      @(negedge clk);
      in_data = 8'hFF;
      cfg_valid = 1; cfg_kind = 2'd0; cfg_mask = '0; cfg_tgt = 3'd5;
      chk(in_ready == 0, "R9 busy blocks words", 32'(in_ready), 0);
      @(negedge clk);
      in_valid = 0; cfg_valid = 0;
      while (!out_valid) @(negedge clk);
      chk(out_data == 8'h03, "R9 first word result", 32'(out_data), 32'h03);
      run(8'h00, 0, r, lat);
      chk(r == 8'h03, "R9 busy descriptor not stored", 32'(r), 32'h03);

      // R7 round trip over a random list, R12 bijection
      cfg_wipe();
      load_random(20);
      for (int w = 0; w < 16; w++) begin
         logic [NW-1:0] wi = NW'($urandom);
         run(wi, 0, r, lat);
         run(r, 1, r2, lat);
         chk(r2 == wi, "R7 random round trip", 32'(r2), 32'(wi));
      end
      dup = 0;
      for (int w = 0; w < 256; w++) seen[w] = 0;
      for (int w = 0; w < 256; w++) begin
         run(NW'(w), 0, r, lat);
         if (seen[r]) dup++;
         seen[r] = 1;
      end
      chk(dup == 0, "R12 distinct results", 32'(dup), 0);

      // R10 refusals
      cfg_wipe();
      cfg_put(2'd1, 8'h01, 3'd0, 1'b1, "R10 single control overlap");
      cfg_put(2'd2, 8'h81, 3'd7, 1'b1, "R10 multi control overlap");
      cfg_put(2'd1, 8'h06, 3'd0, 1'b1, "R10 single control two bits");
      cfg_put(2'd1, 8'h00, 3'd0, 1'b1, "R10 single control no bits");
      cfg_put(2'd3, 8'h00, 3'd2, 1'b1, "R10 exchange empty mask");
      run(8'h5A, 0, r, lat);
      chk(r == 8'h5A, "R10 refused not stored", 32'(r), 32'h5A);
      chk(lat == 1, "R10 refused latency", 32'(lat), 1);

      // R10 full list, R8 long latency
      for (int s = 0; s < MG; s++) cfg_put(2'd0, 8'h00, 3'd0, 1'b0, "R10 fill");
      cfg_put(2'd0, 8'h00, 3'd1, 1'b1, "R10 full list refusal");
      run(8'h00, 0, r, lat);
      chk(r == 8'h00, "R10 extra entry absent", 32'(r), 32'h00);
      chk(lat == MG + 1, "R8 full list latency", 32'(lat), 32'(MG + 1));

      // R11 clear
      cfg_wipe();
      run(8'h77, 1, r, lat);
      chk(r == 8'h77, "R11 cleared identity", 32'(r), 32'h77);
      chk(lat == 1, "R11 cleared latency", 32'(lat), 1);

      @(negedge clk);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule